// File: doc/BRIEF.md
# Processor-Side Interrupt Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate: an interrupt ID, an 8-bit priority and, for software-generated interrupts, the number of the CPU that raised it. The block decides whether that candidate may interrupt the processor. It weighs the candidate against a programmable priority floor, against an enable bit, and against the priority of the interrupt the processor is already servicing. The comparison with the interrupt in service uses only the group part of each priority. A binary-point setting selects how many low bits of the priority are subpriority.

Software reaches the block through a simple single-cycle register bus. Reading the claim register takes the offered interrupt: it returns the ID, records the interrupt as in service, and sends a one-cycle claim event to the distributor. Writing an ID to the completion register ends service of that interrupt and sends a one-cycle completion event to the distributor. A peek register returns the same value as a claim would, without side effects. Interrupts in service are held on a small stack, so that nested completions restore the earlier running priority.

The claim and completion events are single-cycle pulses with no ready signal. The distributor must accept them in the cycle they appear, so they carry no back-pressure. The candidate input is a plain level that the distributor updates whenever its state changes.

Top module: `cpuif_unit`

## Requirements
- R1: After reset the enable bit is 0, the priority floor is 0x00, the binary point is 0, the running priority reads 0xFF and `irq_out` is low.
- R2: Register offsets are: enable at 0x00 (bit 0), priority floor at 0x04 (bits [7:0]), binary point at 0x08 (bits [2:0]), claim at 0x0C, completion at 0x10, running priority at 0x14 and peek at 0x18. Unused bits read 0, writes to the read-only offsets have no effect, and unmapped offsets read 0.
- R3: With no interrupt in service, `irq_out` is high exactly when the enable bit is 1, `cand_valid` is 1 and `cand_prio` is numerically strictly below the priority floor. A lower value means more urgent.
- R4: While an interrupt is in service, a candidate also needs `(cand_prio & G) < (running & G)` to be signalled, where G = 0xFF << (binary point + 1), truncated to 8 bits. A binary point of 7 therefore blocks all preemption.
- R5: A claim read of a signalled candidate returns bit fields [9:0] = ID, [12:10] = source CPU when ID < 16 and 0 otherwise, and [31:13] = 0. It also pulses `claim_valid` for one cycle with `claim_id` and `claim_src`, and from the next cycle the running priority equals the claimed priority.
- R6: A claim read when nothing is signalled returns 1023, raises no claim pulse and leaves the running priority unchanged.
- R7: A peek read returns the value a claim read would return in that cycle, and raises no claim pulse and changes no state.
- R8: A completion write whose bits [9:0] equal the ID on top of the in-service stack pops that entry, so the running priority returns to the previous entry, or to 0xFF when the stack is empty. The write also pulses `done_valid` with `done_id`.
- R9: A completion write of an ID that is not on top is still forwarded on `done_valid`, but leaves the in-service stack unchanged. A completion write of 1023 produces no pulse and changes nothing.
- R10: When the in-service stack holds ACT_DEPTH entries (4 by default), no candidate is signalled and a claim read returns 1023.
- R11: The running priority register reads the priority of the most recently claimed interrupt still in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority (lower is more urgent) |
| cand_src | input | 3 | Requesting CPU for software-generated IDs |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| claim_valid | output | 1 | One-cycle claim event to the distributor |
| claim_id | output | 10 | ID that was claimed |
| claim_src | output | 3 | Source CPU field of the claimed ID |
| done_valid | output | 1 | One-cycle completion event to the distributor |
| done_id | output | 10 | ID that was completed |

## Verification
Some properties are checked on every cycle. The stack never takes a push while full. A claim pulse always leaves the claimed priority as the running priority. Peek reads, and claim reads that find nothing, leave the running priority untouched. A completion pulse never carries 1023, and claim and completion pulses never coincide. Other behaviour depends on the arithmetic and needs the bench's scenarios: the strict floor comparison across every priority value, the group-priority preemption for each of the eight binary points, correct restoration through nested completions, and the field layout of claim values for software-generated and other IDs.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int CPU_W  = 3;
  localparam int BP_W   = 3;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SGI_LIMIT = 16;

  localparam logic [ID_W-1:0]   NO_IRQ_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_FLOOR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_BINPT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLAIM  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DONE   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RUN    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEEK   = 8'h18;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } svc_entry_t;

  // Mask keeping the group-priority bits for a given binary point.
  function automatic logic [PRIO_W-1:0] group_mask(input logic [BP_W-1:0] bp);
    logic [PRIO_W:0] wide;
    wide = {1'b0, {PRIO_W{1'b1}}} << ({1'b0, bp} + 4'd1);
    return wide[PRIO_W-1:0];
  endfunction
endpackage

// File: rtl/cpuif_cfg_regs.sv
module cpuif_cfg_regs
  import cpuif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              enable,
  output logic [PRIO_W-1:0] floor_prio,
  output logic [BP_W-1:0]   binpt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      floor_prio <= '0;
      binpt      <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_ENABLE: enable     <= wdata[0];
        OFS_FLOOR:  floor_prio <= wdata[PRIO_W-1:0];
        OFS_BINPT:  binpt      <= wdata[BP_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpuif_svc_stack.sv
module cpuif_svc_stack
  import cpuif_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  svc_entry_t push_e,
  input  logic       pop,
  output svc_entry_t top,
  output logic       empty,
  output logic       full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  svc_entry_t       mem [DEPTH];
  logic [CNT_W-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && !full) begin
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) == cnt) mem[i] <= push_e;
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i + 1) == cnt) top = mem[i];
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/cpuif_gate.sv
module cpuif_gate
  import cpuif_pkg::*;
(
  input  logic              enable,
  input  logic [PRIO_W-1:0] floor_prio,
  input  logic [BP_W-1:0]   binpt,
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              stk_empty,
  input  logic              stk_full,
  input  logic [PRIO_W-1:0] run_prio,
  output logic              signal
);
  logic [PRIO_W-1:0] gmask;
  logic              below_floor;
  logic              preempts;

  always_comb begin
    gmask       = group_mask(binpt);
    below_floor = cand_prio < floor_prio;
    preempts    = stk_empty || ((cand_prio & gmask) < (run_prio & gmask));
    signal      = enable && cand_valid && below_floor && preempts && !stk_full;
  end
endmodule

// File: rtl/cpuif_unit.sv
module cpuif_unit
  import cpuif_pkg::*;
#(
  parameter int ACT_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [CPU_W-1:0]  cand_src,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              claim_valid,
  output logic [ID_W-1:0]   claim_id,
  output logic [CPU_W-1:0]  claim_src,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id
);
  localparam int PAD_W = DATA_W - ID_W - CPU_W;

  logic              enable;
  logic [PRIO_W-1:0] floor_prio;
  logic [BP_W-1:0]   binpt;
  logic              wr_en, rd_en;
  logic              stk_empty, stk_full, stk_push, stk_pop;
  svc_entry_t        stk_top, new_e;
  logic [PRIO_W-1:0] run_prio;
  logic              signal;
  logic [CPU_W-1:0]  src_field;
  logic [DATA_W-1:0] take_word;
  logic [ID_W-1:0]   wr_id;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;
  assign wr_id = bus_wdata[ID_W-1:0];

  cpuif_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .enable(enable), .floor_prio(floor_prio), .binpt(binpt)
  );

  assign run_prio = stk_empty ? IDLE_PRIO : stk_top.prio;

  cpuif_gate u_gate (
    .enable(enable), .floor_prio(floor_prio), .binpt(binpt),
    .cand_valid(cand_valid), .cand_prio(cand_prio),
    .stk_empty(stk_empty), .stk_full(stk_full), .run_prio(run_prio),
    .signal(signal)
  );

  assign irq_out = signal;

  // Value a claim would return this cycle.
  always_comb begin
    src_field = (cand_id < ID_W'(SGI_LIMIT)) ? cand_src : '0;
    if (signal) take_word = {{PAD_W{1'b0}}, src_field, cand_id};
    else        take_word = {{(DATA_W-ID_W){1'b0}}, NO_IRQ_ID};
  end

  assign new_e.id   = cand_id;
  assign new_e.prio = cand_prio;
  assign stk_push   = rd_en && (bus_addr == OFS_CLAIM) && signal;
  assign stk_pop    = wr_en && (bus_addr == OFS_DONE) && (wr_id != NO_IRQ_ID)
                      && !stk_empty && (stk_top.id == wr_id);

  cpuif_svc_stack #(.DEPTH(ACT_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .push_e(new_e), .pop(stk_pop),
    .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  assign claim_valid = stk_push;
  assign claim_id    = cand_id;
  assign claim_src   = src_field;
  assign done_valid  = wr_en && (bus_addr == OFS_DONE) && (wr_id != NO_IRQ_ID);
  assign done_id     = wr_id;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        OFS_ENABLE: bus_rdata = {{(DATA_W-1){1'b0}}, enable};
        OFS_FLOOR:  bus_rdata = {{(DATA_W-PRIO_W){1'b0}}, floor_prio};
        OFS_BINPT:  bus_rdata = {{(DATA_W-BP_W){1'b0}}, binpt};
        OFS_CLAIM:  bus_rdata = take_word;
        OFS_RUN:    bus_rdata = {{(DATA_W-PRIO_W){1'b0}}, run_prio};
        OFS_PEEK:   bus_rdata = take_word;
        default:    bus_rdata = '0;
      endcase
    end
  end

  p_claim_sets_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    claim_valid |=> (run_prio == $past(cand_prio)));
  p_empty_claim_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_CLAIM && !claim_valid) |=> $stable(run_prio));
  p_peek_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_PEEK) |=> $stable(run_prio));
  p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_id != NO_IRQ_ID));
  p_events_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({claim_valid, done_valid}));
  p_irq_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (cand_prio < floor_prio) && enable);
endmodule

// File: tb/sim_cpuif_unit.sv
`timescale 1ns/1ps
module sim_cpuif_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = 8'hFF;
  logic [2:0]  cand_src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, claim_valid, done_valid;
  logic [9:0]  claim_id, done_id;
  logic [2:0]  claim_src;

  int checks = 0, failures = 0;
  logic        seen_claim, seen_done;
  logic [9:0]  seen_claim_id, seen_done_id;
  logic [2:0]  seen_claim_src;

  always #2 clk = ~clk;

  cpuif_unit u0 (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .cand_src(cand_src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .claim_valid(claim_valid), .claim_id(claim_id),
    .claim_src(claim_src), .done_valid(done_valid), .done_id(done_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    seen_claim = claim_valid; seen_claim_id = claim_id; seen_claim_src = claim_src;
    @(posedge clk); #0.5;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    seen_done = done_valid; seen_done_id = done_id;
    @(posedge clk); #0.5;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p,
                       input logic [2:0] s);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_prio = p; cand_src = s;
    #1;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  gm;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;

    // R1 reset state, R11 idle running priority
    rd(8'h00, d); chk("R1 enable", d, 0);
    rd(8'h04, d); chk("R1 floor", d, 0);
    rd(8'h08, d); chk("R1 binpt", d, 0);
    rd(8'h14, d); chk("R11 running idle", d, 32'hFF);
    chk("R1 irq", {31'b0, irq_out}, 0);

    // R2 field widths, read-only and unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 enable width", d, 1);
    wr(8'h04, 32'h00AB_CD12); rd(8'h04, d); chk("R2 floor width", d, 32'h12);
    wr(8'h08, 32'h0000_00FD); rd(8'h08, d); chk("R2 binpt width", d, 5);
    wr(8'h14, 32'h0000_0011); rd(8'h14, d); chk("R2 running read-only", d, 32'hFF);
    rd(8'h1C, d); chk("R2 unmapped", d, 0);
    wr(8'h08, 0);

    // R3 floor sweep, empty stack
    for (int f = 0; f < 5; f++) begin
      logic [7:0] fl;
      fl = (f == 0) ? 8'h00 : (f == 1) ? 8'h01 : (f == 2) ? 8'h80 : (f == 3) ? 8'hF0 : 8'hFF;
      wr(8'h04, {24'b0, fl});
      for (int p = 0; p < 256; p++) begin
        offer(1'b1, 10'd40, p[7:0], 3'd0);
        chk("R3 floor sweep", {31'b0, irq_out}, {31'b0, (p[7:0] < fl)});
      end
    end
    offer(1'b0, 10'd40, 8'h00, 3'd0); chk("R3 no candidate", {31'b0, irq_out}, 0);
    wr(8'h00, 0);
    offer(1'b1, 10'd40, 8'h00, 3'd0); chk("R3 disabled", {31'b0, irq_out}, 0);
    wr(8'h00, 1);
    wr(8'h04, 32'hF0);

    // R7 peek without side effects
    offer(1'b1, 10'd40, 8'h10, 3'd5);
    rd(8'h18, d); chk("R7 peek spi", d, 40); chk("R7 no claim", {31'b0, seen_claim}, 0);
    rd(8'h14, d); chk("R7 running kept", d, 32'hFF);
    offer(1'b1, 10'd3, 8'h10, 3'd5);
    rd(8'h18, d); chk("R7 peek sgi", d, (32'd5 << 10) | 32'd3);

    // R5 claim of software-generated ID
    offer(1'b1, 10'd3, 8'h20, 3'd5);
    rd(8'h0C, d); chk("R5 claim word", d, (32'd5 << 10) | 32'd3);
    chk("R5 claim pulse", {31'b0, seen_claim}, 1);
    chk("R5 claim id", {22'b0, seen_claim_id}, 3);
    chk("R5 claim src", {29'b0, seen_claim_src}, 5);
    rd(8'h14, d); chk("R5 running", d, 32'h20);
    wr(8'h10, 3); chk("R8 done pulse", {31'b0, seen_done}, 1);
    rd(8'h14, d); chk("R8 idle again", d, 32'hFF);

    // R4 preemption sweep for every binary point, running 0x80
    for (int bp = 0; bp < 8; bp++) begin
      wr(8'h08, bp);
      offer(1'b1, 10'd50, 8'h80, 3'd0);
      rd(8'h0C, d); chk("R5 claim spi", d, 50);
      gm = 8'((9'h0FF << (bp + 1)));
      for (int p = 0; p < 256; p += 3) begin
        offer(1'b1, 10'd51, p[7:0], 3'd0);
        chk("R4 preempt sweep", {31'b0, irq_out},
            {31'b0, (p[7:0] < 8'hF0) && ((p[7:0] & gm) < (8'h80 & gm))});
      end
      wr(8'h10, 50); chk("R8 done id", {22'b0, seen_done_id}, 50);
      rd(8'h14, d); chk("R8 restore idle", d, 32'hFF);
    end
    wr(8'h08, 0);

    // R8 nesting, R11 most recent
    offer(1'b1, 10'd60, 8'h80, 3'd0); rd(8'h0C, d);
    offer(1'b1, 10'd61, 8'h40, 3'd0); rd(8'h0C, d); chk("R5 nested claim", d, 61);
    rd(8'h14, d); chk("R11 running nested", d, 32'h40);
    wr(8'h10, 61); rd(8'h14, d); chk("R8 restore outer", d, 32'h80);
    wr(8'h10, 60); rd(8'h14, d); chk("R8 restore idle", d, 32'hFF);

    // R9 mismatched and spurious completions
    offer(1'b1, 10'd70, 8'h50, 3'd0); rd(8'h0C, d);
    wr(8'h10, 99); chk("R9 mismatch forwarded", {31'b0, seen_done}, 1);
    chk("R9 mismatch id", {22'b0, seen_done_id}, 99);
    rd(8'h14, d); chk("R9 mismatch keeps", d, 32'h50);
    wr(8'h10, 1023); chk("R9 spurious no pulse", {31'b0, seen_done}, 0);
    rd(8'h14, d); chk("R9 spurious keeps", d, 32'h50);
    wr(8'h10, 70); rd(8'h14, d); chk("R8 final pop", d, 32'hFF);

    // R6 nothing signalled
    wr(8'h04, 0);
    offer(1'b1, 10'd80, 8'h00, 3'd0);
    rd(8'h0C, d); chk("R6 spurious id", d, 1023);
    chk("R6 no pulse", {31'b0, seen_claim}, 0);
    rd(8'h14, d); chk("R6 running kept", d, 32'hFF);
    wr(8'h04, 32'hFF);
    offer(1'b0, 10'd80, 8'h00, 3'd0);
    rd(8'h0C, d); chk("R6 no candidate", d, 1023);

    // R10 full stack
    for (int k = 0; k < 4; k++) begin
      offer(1'b1, 10'(100 + k), 8'(8'h80 - 8'h20 * k), 3'd0);
      rd(8'h0C, d); chk("R10 fill", d, 100 + k);
    end
    offer(1'b1, 10'd110, 8'h00, 3'd0);
    chk("R10 full no irq", {31'b0, irq_out}, 0);
    rd(8'h0C, d); chk("R10 full claim", d, 1023);
    rd(8'h14, d); chk("R10 running top", d, 32'h20);
    for (int k = 3; k >= 0; k--) wr(8'h10, 100 + k);
    rd(8'h14, d); chk("R10 drained", d, 32'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule